// File: doc/BRIEF.md
# Token-Passing Chip-Chain Readout Manager

This block runs the readout of one data link that serves a chain of up to 16 pixel readout chips. The link controller sends it a trigger and a reset. It passes both on to the chips, and it also hands the chips its own clock. Each trigger it accepts becomes one token pass, made of four steps. First it emits a header word that carries an event number. Then it injects a single token into the first chip of the chain. It waits until the last chip hands the token back. Finally it emits a trailer word that reports how the pass ended.

Only one pass runs at a time. Triggers that arrive while a pass is running wait in a small first-in first-out queue and are served in the order they arrived. Two static enable inputs switch off the forwarding of triggers and the injection of tokens, each on its own. A programmable limit ends a pass whose token never comes back. The block runs in the 40 MHz readout clock domain.

Top module: `tkn_link_mgr`

## Requirements
- R1: While `rst_n` is low and right after it rises, `word_vld`, `tok_out`, `chip_trig` and `chip_rst` are 0 and the pending queue is empty.
- R2: With `trig_fwd_en`=1, a high `ctl_trig` shows on `chip_trig` one cycle later and is accepted for readout. With `trig_fwd_en`=0 the trigger is not forwarded, not queued and not counted.
- R3: When the manager is idle, an accepted trigger yields a header one cycle after acceptance. The header is `word[15:12]`=4'hA, `word[11:8]`=0 and `word[7:0]`=event number.
- R4: One cycle after the header, `tok_out` pulses high for exactly one cycle, provided `tok_fwd_en`=1.
- R5: The trailer appears one cycle after the cycle in which `tok_ret` is sampled high during the wait. The trailer is `word[15:12]`=4'hC, `word[11:10]`=0, `word[9]`=overflow, `word[8]`=timeout and `word[7:0]`=event number.
- R6: The event number starts at 0 after reset, rises by one for each accepted trigger, and wraps from 255 to 0.
- R7: Triggers that arrive during a pass are served as later passes in the order they arrived, one pass after another.
- R8: The queue holds 8 pending triggers. A trigger that finds it full is dropped and not counted, and the next trailer has its overflow bit set. The trailer after that has the bit clear.
- R9: Suppose the wait begins after the edge that raises `tok_out` and no return is sampled in `tmo_lim` cycles. Then the pass ends with the timeout bit set, and the trailer appears `tmo_lim`+1 cycles after the `tok_out` pulse begins. A return that is sampled on the last allowed edge still counts as a return.
- R10: With `tok_fwd_en`=0 no token is injected and the trailer follows two cycles after the header.
- R11: A high `ctl_rst` shows on `chip_rst` one cycle later. It also clears the queue, the event number and the flags, and returns the manager to idle.
- R12: `tok_ret` has no effect outside the wait for a returning token.
- R13: `chip_clk` is the manager clock itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_trig | input | 1 | Trigger from the link controller |
| ctl_rst | input | 1 | Synchronous reset from the link controller |
| trig_fwd_en | input | 1 | Enable for forwarding and accepting triggers |
| tok_fwd_en | input | 1 | Enable for token injection |
| tmo_lim | input | TO_W (12) | Token wait limit in cycles, at least 1 |
| tok_ret | input | 1 | Token returned by the last chip |
| chip_clk | output | 1 | Clock to the chips |
| chip_trig | output | 1 | Trigger to the chips |
| chip_rst | output | 1 | Reset to the chips |
| tok_out | output | 1 | Token pulse to the first chip |
| word_vld | output | 1 | Header or trailer word valid |
| word | output | 16 | Header or trailer word |

## Verification
The assertions assume that `tok_fwd_en`, `trig_fwd_en` and `tmo_lim` stay constant during a pass and that `tmo_lim` is never 0. The stimulus keeps to this by changing the configuration only while the manager is idle with an empty queue. The assertions make no assumption about when `tok_ret` is high. The stimulus therefore also holds `tok_ret` high across whole passes, so that its effect outside the wait can be seen at the ports.

// File: rtl/tkn_pkg.sv
package tkn_pkg;

    localparam int WORD_W = 16;
    localparam int EVT_W  = 8;

    localparam logic [3:0] HDR_TAG = 4'hA;
    localparam logic [3:0] TRL_TAG = 4'hC;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INJ  = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_TRL  = 2'd3
    } sq_state_e;

    function automatic logic [WORD_W-1:0] mk_hdr(input logic [EVT_W-1:0] evt);
        return {HDR_TAG, 4'h0, evt};
    endfunction

    function automatic logic [WORD_W-1:0] mk_trl(input logic [EVT_W-1:0] evt,
                                                 input logic ovf,
                                                 input logic tmo);
        return {TRL_TAG, 2'b00, ovf, tmo, evt};
    endfunction

endpackage

// File: rtl/tkn_trig_queue.sv
module tkn_trig_queue #(
    parameter int DEPTH = 8,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    output logic             empty,
    output logic [EVT_W-1:0] head,
    output logic             drop
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][EVT_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
        logic [EVT_W-1:0]            evt;
    } q_st_t;

    q_st_t st_q, st_d;
    logic  full, acc, pop_ok;

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && !empty;
        acc    = push && (!full || pop_ok);
        drop   = push && full && !pop_ok;
        if (acc) begin
            st_d.mem[st_q.wr] = st_q.evt;
            st_d.wr  = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + PTR_W'(1);
            st_d.evt = st_q.evt + EVT_W'(1);
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + PTR_W'(1);
        end
        st_d.cnt = st_q.cnt + CNT_W'(acc) - CNT_W'(pop_ok);
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clr) |=> full);

    // R7
    push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clr) |=> !empty);

endmodule

// File: rtl/tkn_pass_seq.sv
module tkn_pass_seq
    import tkn_pkg::*;
#(
    parameter int TO_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              q_empty,
    input  logic [EVT_W-1:0]  q_head,
    input  logic              q_drop,
    input  logic              tok_en,
    input  logic              tok_ret,
    input  logic [TO_W-1:0]   tmo_lim,
    output logic              pop,
    output logic              tok_out,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        sq_state_e         st;
        logic [TO_W-1:0]   cnt;
        logic [EVT_W-1:0]  evt;
        logic              tmo;
        logic              ovf;
        logic              tok;
        logic              vld;
        logic [WORD_W-1:0] word;
    } sq_st_t;

    sq_st_t st_q, st_d;
    logic   ovf_now, lim_hit;

    assign ovf_now = st_q.ovf | q_drop;
    assign lim_hit = ({1'b0, st_q.cnt} + (TO_W+1)'(1)) >= {1'b0, tmo_lim};

    always_comb begin
        st_d     = st_q;
        st_d.tok = 1'b0;
        st_d.vld = 1'b0;
        st_d.ovf = ovf_now;
        pop      = 1'b0;
        case (st_q.st)
            SQ_IDLE: begin
                if (!q_empty) begin
                    pop       = 1'b1;
                    st_d.evt  = q_head;
                    st_d.tmo  = 1'b0;
                    st_d.vld  = 1'b1;
                    st_d.word = mk_hdr(q_head);
                    st_d.st   = SQ_INJ;
                end
            end
            SQ_INJ: begin
                if (tok_en) begin
                    st_d.tok = 1'b1;
                    st_d.cnt = '0;
                    st_d.st  = SQ_WAIT;
                end else begin
                    st_d.st = SQ_TRL;
                end
            end
            SQ_WAIT: begin
                if (tok_ret) begin
                    st_d.st = SQ_TRL;
                end else if (lim_hit) begin
                    st_d.tmo = 1'b1;
                    st_d.st  = SQ_TRL;
                end else begin
                    st_d.cnt = st_q.cnt + TO_W'(1);
                end
            end
            default: begin
                st_d.vld  = 1'b1;
                st_d.word = mk_trl(st_q.evt, ovf_now, st_q.tmo);
                st_d.ovf  = 1'b0;
                st_d.st   = SQ_IDLE;
            end
        endcase
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok_out  = st_q.tok;
    assign word_vld = st_q.vld;
    assign word     = st_q.word;

    // R4
    tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);

    // R10
    tok_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> $past(tok_en));

    // R5
    word_tok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && tok_out));

    // R3
    hdr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word[15:12] == HDR_TAG) |=> !word_vld);

    // R9
    cnt_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SQ_WAIT && tmo_lim != '0) |-> st_q.cnt < tmo_lim);

endmodule

// File: rtl/tkn_link_mgr.sv
module tkn_link_mgr
    import tkn_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_trig,
    input  logic              ctl_rst,
    input  logic              trig_fwd_en,
    input  logic              tok_fwd_en,
    input  logic [TO_W-1:0]   tmo_lim,
    input  logic              tok_ret,
    output logic              chip_clk,
    output logic              chip_trig,
    output logic              chip_rst,
    output logic              tok_out,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic trig;
        logic rst;
    } fwd_st_t;

    fwd_st_t          fwd_q, fwd_d;
    logic             push, pop, q_empty, q_drop;
    logic [EVT_W-1:0] q_head;

    assign push = ctl_trig && trig_fwd_en;

    always_comb begin
        fwd_d      = fwd_q;
        fwd_d.trig = push;
        fwd_d.rst  = ctl_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign chip_clk  = clk;
    assign chip_trig = fwd_q.trig;
    assign chip_rst  = fwd_q.rst;

    tkn_trig_queue #(
        .DEPTH (DEPTH),
        .EVT_W (EVT_W)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl_rst),
        .push  (push),
        .pop   (pop),
        .empty (q_empty),
        .head  (q_head),
        .drop  (q_drop)
    );

    tkn_pass_seq #(
        .TO_W (TO_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_rst),
        .q_empty  (q_empty),
        .q_head   (q_head),
        .q_drop   (q_drop),
        .tok_en   (tok_fwd_en),
        .tok_ret  (tok_ret),
        .tmo_lim  (tmo_lim),
        .pop      (pop),
        .tok_out  (tok_out),
        .word_vld (word_vld),
        .word     (word)
    );

    // R2
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(trig_fwd_en) |-> !chip_trig);

    // R11
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rst) |-> (!word_vld && !tok_out));

endmodule

// File: tb/sim_tkn_link_mgr.sv
module sim_tkn_link_mgr;

    localparam int TO_W = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_trig = 1'b0;
    logic            ctl_rst = 1'b0;
    logic            trig_fwd_en = 1'b0;
    logic            tok_fwd_en = 1'b0;
    logic [TO_W-1:0] tmo_lim = 12'd5;
    logic            tok_man = 1'b0;
    logic            tok_hold = 1'b0;
    logic            tok_ret;
    logic            chip_clk, chip_trig, chip_rst, tok_out, word_vld;
    logic [15:0]     word;

    assign tok_ret = tok_man | tok_hold;

    always #4 clk = ~clk;

    tkn_link_mgr #(.DEPTH(8), .TO_W(TO_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_trig    (ctl_trig),
        .ctl_rst     (ctl_rst),
        .trig_fwd_en (trig_fwd_en),
        .tok_fwd_en  (tok_fwd_en),
        .tmo_lim     (tmo_lim),
        .tok_ret     (tok_ret),
        .chip_clk    (chip_clk),
        .chip_trig   (chip_trig),
        .chip_rst    (chip_rst),
        .tok_out     (tok_out),
        .word_vld    (word_vld),
        .word        (word)
    );

    // tok_en, return delay, limit
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 8'd0, 8'd5},
        {1'b1, 8'd3, 8'd5},
        {1'b1, 8'd4, 8'd5},
        {1'b1, 8'd5, 8'd5},
        {1'b1, 8'd9, 8'd2},
        {1'b0, 8'd0, 8'd5},
        {1'b1, 8'd1, 8'd1},
        {1'b1, 8'd0, 8'd1}
    };

    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;
    int          ncap = 0;
    int          ntok = 0;
    logic [15:0] cap [1024];
    logic [7:0]  evt_exp = 8'd0;

    always @(negedge clk) begin
        if (word_vld && ncap < 1024) begin
            cap[ncap] = word;
            ncap++;
        end
        if (tok_out) ntok++;
    end

    function automatic logic [15:0] hdr_w(input logic [7:0] e);
        return {4'hA, 4'h0, e};
    endfunction

    function automatic logic [15:0] trl_w(input logic [7:0] e, input logic o, input logic t);
        return {4'hC, 2'b00, o, t, e};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // one trigger from an idle manager, run to the trailer
    task automatic one_pass(input logic ten, input int dly, input int lim, input logic ovf_exp);
        tok_fwd_en = ten;
        tmo_lim    = TO_W'(lim);
        ctl_trig   = 1'b1;
        @(negedge clk);
        ctl_trig = 1'b0;
        check("R2 forward", {31'd0, chip_trig}, 32'd1);
        @(negedge clk);
        check("R3 header", {15'd0, word_vld, word}, {15'd0, 1'b1, hdr_w(evt_exp)});
        @(negedge clk);
        check("R4 token", {31'd0, tok_out}, {31'd0, ten});
        if (!ten) begin
            @(negedge clk);
            check("R10 trailer", {15'd0, word_vld, word}, {15'd0, 1'b1, trl_w(evt_exp, ovf_exp, 1'b0)});
        end else if (dly < lim) begin
            repeat (dly) @(negedge clk);
            tok_man = 1'b1;
            @(negedge clk);
            tok_man = 1'b0;
            check("R5 no early word", {31'd0, word_vld}, 32'd0);
            @(negedge clk);
            check("R5 trailer", {15'd0, word_vld, word}, {15'd0, 1'b1, trl_w(evt_exp, ovf_exp, 1'b0)});
        end else begin
            repeat (lim) @(negedge clk);
            check("R9 no early word", {31'd0, word_vld}, 32'd0);
            @(negedge clk);
            check("R9 timeout trailer", {15'd0, word_vld, word}, {15'd0, 1'b1, trl_w(evt_exp, ovf_exp, 1'b1)});
        end
        evt_exp = evt_exp + 8'd1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int base;
        int tbase;
        repeat (3) @(negedge clk);
        check("R1 reset vld", {31'd0, word_vld}, 32'd0);
        check("R1 reset tok", {31'd0, tok_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {28'd0, word_vld, tok_out, chip_trig, chip_rst}, 32'd0);
        check("R13 clock low", {31'd0, chip_clk}, {31'd0, clk});
        @(posedge clk);
        #1;
        check("R13 clock high", {31'd0, chip_clk}, 32'd1);
        @(negedge clk);

        // R2: triggers disabled are ignored
        base = ncap;
        ctl_trig = 1'b1;
        @(negedge clk);
        ctl_trig = 1'b0;
        check("R2 disabled forward", {31'd0, chip_trig}, 32'd0);
        repeat (6) @(negedge clk);
        check("R2 disabled no word", ncap - base, 32'd0);
        trig_fwd_en = 1'b1;

        // vector table: single passes
        for (int i = 0; i < 8; i++) begin
            one_pass(VEC[i][16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b0);
        end

        // R7/R8/R12: queue fills during a long pass, one trigger dropped
        tok_fwd_en = 1'b1;
        tmo_lim    = 12'd200;
        base  = ncap;
        tbase = ntok;
        ctl_trig = 1'b1;
        repeat (10) @(negedge clk);
        ctl_trig = 1'b0;
        tok_hold = 1'b1;
        for (int w = 0; w < 300 && (ncap - base) < 18; w++) @(negedge clk);
        tok_hold = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 word count", ncap - base, 32'd18);
        check("R12 token count", ntok - tbase, 32'd9);
        for (int k = 0; k < 9; k++) begin
            check("R7 header order", {16'd0, cap[base + 2*k]}, {16'd0, hdr_w(evt_exp + 8'(k))});
            check("R8 trailer flag", {16'd0, cap[base + 2*k + 1]},
                  {16'd0, trl_w(evt_exp + 8'(k), k == 0, 1'b0)});
        end
        evt_exp = evt_exp + 8'd9;
        tmo_lim = 12'd5;
        one_pass(1'b1, 1, 5, 1'b0);   // R8: drop not counted, flag cleared

        // R11: controller reset clears pending work
        tmo_lim  = 12'd200;
        ctl_trig = 1'b1;
        repeat (3) @(negedge clk);
        ctl_trig = 1'b0;
        ctl_rst  = 1'b1;
        @(negedge clk);
        ctl_rst = 1'b0;
        check("R11 chip reset", {31'd0, chip_rst}, 32'd1);
        base  = ncap;
        tbase = ntok;
        repeat (12) @(negedge clk);
        check("R11 queue cleared", ncap - base, 32'd0);
        check("R11 no token", ntok - tbase, 32'd0);
        check("R11 chip reset low", {31'd0, chip_rst}, 32'd0);
        evt_exp = 8'd0;
        one_pass(1'b1, 0, 5, 1'b0);

        // R6: event number wraps
        tok_fwd_en = 1'b0;
        base = ncap;
        for (int j = 0; j < 256; j++) begin
            ctl_trig = 1'b1;
            @(negedge clk);
            ctl_trig = 1'b0;
            repeat (4) @(negedge clk);
        end
        check("R6 pass count", ncap - base, 32'd512);
        check("R6 header 255", {16'd0, cap[base + 508]}, {16'd0, hdr_w(8'd255)});
        check("R6 header wrap", {16'd0, cap[base + 510]}, {16'd0, hdr_w(8'd0)});

        finish_run();
    end

endmodule